// File: doc/BRIEF.md
# Multidrop Serial Character Receiver with Sticky Error Flag

The block receives asynchronous serial characters of eight data bits on a single input line. An oversampling tick input marks sixteen slots per bit period. The receiver finds a falling edge on the idle-high line and confirms the start bit in the middle of its bit period. It then samples each later bit in the middle of its period: the eight data bits least significant first, an optional ninth bit, and the stop bit. A completed character goes to a holding output, and a ready flag is raised until the consumer acknowledges a read.

A three-bit mode input chooses how the ninth bit is treated. It can be even parity, odd parity, a bit that must be 0, a bit that must be 1, absent, or an address marker for multidrop networks. In the parity modes, a mismatch raises a sticky error flag. In multidrop mode the same flag instead reports that an address character arrived, which is a character whose ninth bit is 1. The flag stays high until a reset-status command clears it. If a new event and that command arrive in the same cycle, the event takes priority.

Top module: `mdrop_uart_rx`

## Requirements
- R1: After reset `rx_rdy` is 0, `err_flag` is 0 and `rx_data` is 0x00.
- R2: A frame consists of a start bit (0), then data bits D0 to D7 with D0 first, then the ninth bit when the mode has one, then a stop bit (1). After the stop bit, `rx_data` holds D7..D0 with D0 at bit 0.
- R3: `rx_rdy` rises when the stop bit is sampled and falls one cycle after `rd_ack` is pulsed.
- R4: A low level on `rxd` counts as a start bit only if `rxd` is still low at the 8th tick after the falling edge is seen. A shorter low pulse produces no character and leaves the receiver idle, ready for the next frame.
- R5: Mode 0 expects even parity, meaning the ninth bit equals the XOR of the data bits. Mode 1 expects odd parity, meaning the ninth bit equals the inverted XOR. A mismatch sets `err_flag`.
- R6: Mode 2 expects a ninth bit of 0 and mode 3 expects a ninth bit of 1. A mismatch sets `err_flag`.
- R7: Modes 4 and 5 have no ninth bit, so the stop bit directly follows D7. In these modes `err_flag` is never set.
- R8: Modes 6 and 7 are multidrop. `err_flag` is set exactly when the received ninth bit is 1, which marks an address character, and the data byte is delivered in either case.
- R9: `err_flag` is sticky. Later error-free characters leave it set, and only a `clr_err` pulse clears it.
- R10: If `clr_err` is high in the same cycle that a character sets the flag, `err_flag` ends up set.
- R11: Only cycles with `tick` high advance the receiver, so spreading the ticks over several clock cycles gives the same results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Oversampling enable, 16 per bit period |
| rxd | input | 1 | Serial line, idle high |
| mode | input | 3 | Ninth-bit treatment (see R5 to R8) |
| rd_ack | input | 1 | Read acknowledge, clears `rx_rdy` |
| clr_err | input | 1 | Reset-status command, clears `err_flag` |
| rx_data | output | 8 | Last received byte |
| rx_rdy | output | 1 | Character available |
| err_flag | output | 1 | Sticky parity error or address-received flag |

## Verification
Characters are sent in each of the eight mode values. Each mode gets a ninth bit that matches the rule and one that breaks it, so a swapped parity sense, a wrong forced value or an inverted address test each gives a different flag result. Asymmetric data bytes show whether the bit order is wrong. A short low glitch followed by a real frame shows that a false start is rejected and that the receiver recovers. A run with ticks every third cycle shows that the enable gating is respected. Other frames check that the flag survives clean characters, that it clears on command, and that it wins over a clear issued in the same cycle.

// File: rtl/mdrop_uart_rx.sv
module mdrop_uart_rx #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd,
  input  logic [2:0]    mode,
  input  logic          rd_ack,
  input  logic          clr_err,
  output logic [DW-1:0] rx_data,
  output logic          rx_rdy,
  output logic          err_flag
);

  localparam int CW = $clog2(OVS);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] MID_CNT  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(OVS - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_NINTH, S_STOP} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [BW-1:0]  bidx;
  logic [DW-1:0]  sh;
  logic           ninth;

  logic has_ninth, multidrop, exp_ninth, mid_hit, bit_hit, char_done, err_set;

  assign multidrop = mode[2] & mode[1];
  assign has_ninth = ~mode[2] | mode[1];
  assign mid_hit   = tick && (cnt == MID_CNT);
  assign bit_hit   = tick && (cnt == LAST_CNT);
  assign char_done = (st == S_STOP) && bit_hit;

  always_comb begin
    case (mode[1:0])
      2'd0:    exp_ninth = ^sh;
      2'd1:    exp_ninth = ~^sh;
      2'd2:    exp_ninth = 1'b0;
      default: exp_ninth = 1'b1;
    endcase
  end

  assign err_set = char_done && has_ninth &&
                   (multidrop ? ninth : (ninth != exp_ninth));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      bidx  <= '0;
      sh    <= '0;
      ninth <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (tick && !rxd) begin
            st  <= S_START;
            cnt <= CW'(1);
          end
        end
        S_START: begin
          if (mid_hit) begin
            cnt  <= '0;
            bidx <= '0;
            st   <= rxd ? S_IDLE : S_DATA;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DATA: begin
          if (bit_hit) begin
            cnt  <= '0;
            sh   <= {rxd, sh[DW-1:1]};
            bidx <= bidx + 1'b1;
            if (bidx == LAST_BIT) st <= has_ninth ? S_NINTH : S_STOP;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_NINTH: begin
          if (bit_hit) begin
            cnt   <= '0;
            ninth <= rxd;
            st    <= S_STOP;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STOP: begin
          if (bit_hit) begin
            cnt <= '0;
            st  <= S_IDLE;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_rdy   <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      if (char_done) begin
        rx_data <= sh;
        rx_rdy  <= 1'b1;
      end else if (rd_ack) begin
        rx_rdy  <= 1'b0;
      end
      if (err_set)      err_flag <= 1'b1;
      else if (clr_err) err_flag <= 1'b0;
    end
  end

  // R3
  rdy_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !char_done) |=> !rx_rdy);

  // R3
  rdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_rdy) |-> $past(st == S_STOP));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !clr_err) |=> err_flag);

  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_err && !err_set) |=> !err_flag);

  // R10
  err_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> err_flag);

  // R7
  no_ninth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[2] && !mode[1]) |-> !err_set);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(st));

endmodule

// File: tb/mdrop_uart_rx_tb.sv
module mdrop_uart_rx_tb_top;

  localparam int OVS = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic [2:0] mode = 3'd0;
  logic       rd_ack = 1'b0;
  logic       clr_err = 1'b0;
  logic [7:0] rx_data;
  logic       rx_rdy;
  logic       err_flag;

  int checks = 0;
  int errors = 0;
  int div = 1;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mdrop_uart_rx #(.OVS(OVS), .DW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .mode(mode),
    .rd_ack(rd_ack), .clr_err(clr_err),
    .rx_data(rx_data), .rx_rdy(rx_rdy), .err_flag(err_flag)
  );

  // {mode, data, ninth, expected flag}
  localparam logic [12:0] VEC [15] = '{
    {3'd0, 8'hA5, 1'b0, 1'b0},
    {3'd0, 8'hA5, 1'b1, 1'b1},
    {3'd0, 8'h07, 1'b1, 1'b0},
    {3'd1, 8'h01, 1'b0, 1'b0},
    {3'd1, 8'h01, 1'b1, 1'b1},
    {3'd2, 8'h3C, 1'b0, 1'b0},
    {3'd2, 8'h3C, 1'b1, 1'b1},
    {3'd3, 8'hF0, 1'b1, 1'b0},
    {3'd3, 8'hF0, 1'b0, 1'b1},
    {3'd4, 8'h81, 1'b0, 1'b0},
    {3'd5, 8'h7E, 1'b1, 1'b0},
    {3'd6, 8'h42, 1'b1, 1'b1},
    {3'd6, 8'h42, 1'b0, 1'b0},
    {3'd7, 8'hFF, 1'b1, 1'b1},
    {3'd7, 8'h00, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      repeat (div - 1) @(negedge clk);
    end
  endtask

  task automatic send_bit(input logic b);
    rxd = b;
    ticks(OVS);
  endtask

  task automatic send_frame(input logic [2:0] m, input logic [7:0] d,
                            input logic nb, input bit clr_at_stop);
    mode = m;
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    if (!(m[2] && !m[1])) send_bit(nb);
    rxd = 1'b1;
    if (clr_at_stop) begin
      ticks(OVS/2 - 1);
      clr_err = 1'b1;
      tick = 1'b1;
      @(negedge clk);
      clr_err = 1'b0;
      tick = 1'b0;
      repeat (div - 1) @(negedge clk);
      ticks(OVS/2);
    end else begin
      ticks(OVS);
    end
    ticks(2);
  endtask

  task automatic pulse_clr();
    clr_err = 1'b1;
    @(negedge clk);
    clr_err = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_ack();
    rd_ack = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rx_rdy == 1'b0, "R1 rdy", rx_rdy, 0);
    chk(err_flag == 1'b0, "R1 err", err_flag, 0);
    chk(rx_data == 8'h00, "R1 data", rx_data, 0);
    rst_n = 1'b1;
    ticks(4);

    foreach (VEC[k]) begin
      pulse_clr();
      send_frame(VEC[k][12:10], VEC[k][9:2], VEC[k][1], 1'b0);
      // R2 data order; R5 R6 R7 R8 flag per mode
      chk(rx_data == VEC[k][9:2], "R2 data", rx_data, VEC[k][9:2]);
      chk(rx_rdy == 1'b1, "R3 rdy set", rx_rdy, 1);
      chk(err_flag == VEC[k][0], "R5_R6_R7_R8 flag", err_flag, VEC[k][0]);
      pulse_ack();
      chk(rx_rdy == 1'b0, "R3 rdy cleared", rx_rdy, 0);
    end

    // R4 glitch rejection then recovery
    pulse_clr();
    mode = 3'd0;
    rxd = 1'b0;
    ticks(4);
    rxd = 1'b1;
    ticks(2 * OVS);
    chk(rx_rdy == 1'b0, "R4 glitch no char", rx_rdy, 0);
    send_frame(3'd0, 8'h96, 1'b0, 1'b0);
    chk(rx_rdy == 1'b1 && rx_data == 8'h96, "R4 recovery", rx_data, 8'h96);
    pulse_ack();

    // R9 sticky across clean character, clear on command
    send_frame(3'd1, 8'h10, 1'b1, 1'b0);
    chk(err_flag == 1'b1, "R9 set", err_flag, 1);
    pulse_ack();
    send_frame(3'd1, 8'h10, 1'b0, 1'b0);
    chk(err_flag == 1'b1, "R9 held", err_flag, 1);
    pulse_ack();
    pulse_clr();
    chk(err_flag == 1'b0, "R9 cleared", err_flag, 0);

    // R10 event beats same-cycle clear
    send_frame(3'd6, 8'h5A, 1'b1, 1'b1);
    chk(err_flag == 1'b1, "R10 priority", err_flag, 1);
    chk(rx_data == 8'h5A, "R10 data", rx_data, 8'h5A);
    pulse_ack();
    pulse_clr();
    // clear without event in the stop cycle
    send_frame(3'd6, 8'h5A, 1'b0, 1'b1);
    chk(err_flag == 1'b0, "R10 no event", err_flag, 0);
    pulse_ack();

    // R11 sparse ticks
    div = 3;
    pulse_clr();
    send_frame(3'd0, 8'hC3, 1'b1, 1'b0);
    chk(rx_data == 8'hC3, "R11 data", rx_data, 8'hC3);
    chk(err_flag == 1'b1, "R11 flag", err_flag, 1);
    pulse_ack();
    rxd = 1'b0;
    repeat (40) @(negedge clk);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
    chk(rx_rdy == 1'b0, "R11 no tick no char", rx_rdy, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule